// File: doc/BRIEF.md
# Interrupt Steering Aggregator

This block gathers a parameterised set of level-sensitive interrupt sources and reduces them to a small number of output lines. Each output stands for one group of 64 consecutive inputs. The last group is partial when the input count is not a multiple of 64. Software controls the block through a 32-bit register port. The port holds an enable mask for each source and a software force bit for each source. It also gives a read-only view of which sources are pending. A separate disable bit for each output can silence a whole group. A small channel selection field is kept in a register and driven to a pin.

The register words are stored in reverse order. Inputs 0 to 31 live in the highest word of each bank and the last 32 inputs live in word 0. The bank base offsets grow with the number of words N. An output line is a registered level. It rises one clock after an enabled source goes active. It falls one clock after the last enabled source in its group goes away.

Top module: `irq_steer_agg`

## Requirements
- R1: After reset, the following all read 0: every mask word, every force word, the output-disable word and the channel word. `irq_out` and `chan_sel` are 0.
- R2: Mask word i is read/write at byte offset 4 + 4·i. Input n is controlled by word N−1−floor(n/32) at bit n mod 32. A mask bit of 1 enables the input.
- R3: Force word i is read/write at byte offset 4·N + 4 + 4·i, with the same input-to-bit mapping as R2. A force bit of 1 makes the input count as active even when its pin is low.
- R4: Status word i at byte offset 8·N + 4 + 4·i reads (pin OR force) AND mask for each input, with the R2 mapping. A masked input never appears in status.
- R5: `irq_out[k]` is 1 one clock after any status bit among inputs 64k to 64k+63 is 1, unless the output is disabled (R6).
- R6: The output-disable word is at byte offset 12·N + 4. Its bit k set to 1 forces `irq_out[k]` to 0 from the next clock. Bits at and above the output count read 0.
- R7: The output-status word at byte offset 12·N + 8 reads `irq_out` in its low bits.
- R8: The channel word at byte offset 0 holds its low CHAN_W bits. Those bits are driven on `chan_sel`. `chan_sel` changes only on a write to offset 0.
- R9: Reads of offsets outside the map return 0. Writes to the status word, the output-status word or unmapped offsets change no state.
- R10: `bus_rdata` shows the register addressed at the previous rising clock edge, so reads to different offsets on back-to-back cycles each return their own value.
- R11: Outputs are level-following. When an active source returns low, its output drops one clock later and no state is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Byte address; bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the address of the previous edge |
| irq_in | input | NUM_IN | Level interrupt sources |
| irq_out | output | NUM_IN/64 rounded up | Group interrupt lines |
| chan_sel | output | CHAN_W | Channel selection field |

## Verification
The assertions assume that `irq_in`, `bus_we` and `bus_addr` are synchronous to `clk` and hold steady around each rising edge. They also assume that only aligned word addresses select registers. The bench drives every input on the falling edge and samples outputs just after the rising edge, which keeps all stimulus inside those assumptions. It exercises each input group through its first and last input and through the word reversal.

// File: rtl/irqs_pkg.sv
`timescale 1ns/1ps
package irqs_pkg;

  typedef enum logic [2:0] {
    RG_NONE, RG_CTRL, RG_MASK, RG_FORCE, RG_STAT, RG_MDIS, RG_MSTAT
  } rgn_e;

  typedef struct packed {
    rgn_e        rgn;
    logic [15:0] idx;
  } dec_t;

  // Map a word offset to a register region and an index within the bank.
  function automatic dec_t decode_word(input int unsigned word, input int unsigned nw);
    dec_t d;
    d.rgn = RG_NONE;
    d.idx = '0;
    if (word == 0) begin
      d.rgn = RG_CTRL;
    end else if (word <= nw) begin
      d.rgn = RG_MASK;
      d.idx = 16'(word - 1);
    end else if (word <= 2 * nw) begin
      d.rgn = RG_FORCE;
      d.idx = 16'(word - 1 - nw);
    end else if (word <= 3 * nw) begin
      d.rgn = RG_STAT;
      d.idx = 16'(word - 1 - 2 * nw);
    end else if (word == 3 * nw + 1) begin
      d.rgn = RG_MDIS;
    end else if (word == 3 * nw + 2) begin
      d.rgn = RG_MSTAT;
    end
    return d;
  endfunction

endpackage

// File: rtl/irqs_regs.sv
`timescale 1ns/1ps
module irqs_regs
  import irqs_pkg::*;
#(
  parameter int NUM_IN = 128,
  parameter int NOUT   = 2,
  parameter int CHAN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  dec_t              dec,
  input  logic [31:0]       wdata,
  output logic [NUM_IN-1:0] mask_q,
  output logic [NUM_IN-1:0] force_q,
  output logic [NOUT-1:0]   mdis_q,
  output logic [CHAN_W-1:0] ctrl_q
);
  localparam int NW = NUM_IN / 32;

  // Storage is kept in input order; word w of a bank covers group NW-1-w.
  for (genvar w = 0; w < NW; w++) begin : g_word
    localparam int BASE = (NW - 1 - w) * 32;
    logic hit;
    assign hit = wr_en && (dec.idx == 16'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[BASE +: 32]  <= '0;
        force_q[BASE +: 32] <= '0;
      end else if (hit) begin
        if (dec.rgn == RG_MASK)  mask_q[BASE +: 32]  <= wdata;
        if (dec.rgn == RG_FORCE) force_q[BASE +: 32] <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdis_q <= '0;
      ctrl_q <= '0;
    end else if (wr_en) begin
      if (dec.rgn == RG_MDIS) mdis_q <= wdata[NOUT-1:0];
      if (dec.rgn == RG_CTRL) ctrl_q <= wdata[CHAN_W-1:0];
    end
  end

endmodule

// File: rtl/irqs_fold.sv
`timescale 1ns/1ps
module irqs_fold #(
  parameter int NUM_IN = 128,
  parameter int NOUT   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] irq_in,
  input  logic [NUM_IN-1:0] mask_q,
  input  logic [NUM_IN-1:0] force_q,
  input  logic [NOUT-1:0]   mdis_q,
  output logic [NUM_IN-1:0] status,
  output logic [NOUT-1:0]   irq_out
);
  logic [NOUT-1:0] grp_any;

  assign status = (irq_in | force_q) & mask_q;

  for (genvar k = 0; k < NOUT; k++) begin : g_grp
    localparam int LO = 64 * k;
    localparam int GW = ((NUM_IN - LO) >= 64) ? 64 : (NUM_IN - LO);
    assign grp_any[k] = |status[LO +: GW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= '0;
    else        irq_out <= grp_any & ~mdis_q;
  end

endmodule

// File: rtl/irqs_rdmux.sv
`timescale 1ns/1ps
module irqs_rdmux
  import irqs_pkg::*;
#(
  parameter int NUM_IN = 128,
  parameter int NOUT   = 2,
  parameter int CHAN_W = 8
) (
  input  dec_t              dec,
  input  logic [NUM_IN-1:0] mask_q,
  input  logic [NUM_IN-1:0] force_q,
  input  logic [NUM_IN-1:0] status,
  input  logic [NOUT-1:0]   mdis_q,
  input  logic [NOUT-1:0]   irq_out,
  input  logic [CHAN_W-1:0] ctrl_q,
  output logic [31:0]       rword
);
  localparam int NW = NUM_IN / 32;

  always_comb begin
    rword = '0;
    unique case (dec.rgn)
      RG_CTRL:  rword[CHAN_W-1:0] = ctrl_q;
      RG_MDIS:  rword[NOUT-1:0]   = mdis_q;
      RG_MSTAT: rword[NOUT-1:0]   = irq_out;
      RG_MASK, RG_FORCE, RG_STAT: begin
        for (int w = 0; w < NW; w++) begin
          if (dec.idx == 16'(w)) begin
            if (dec.rgn == RG_MASK)       rword = mask_q[(NW-1-w)*32 +: 32];
            else if (dec.rgn == RG_FORCE) rword = force_q[(NW-1-w)*32 +: 32];
            else                          rword = status[(NW-1-w)*32 +: 32];
          end
        end
      end
      default: rword = '0;
    endcase
  end

endmodule

// File: rtl/irq_steer_agg.sv
`timescale 1ns/1ps
module irq_steer_agg
  import irqs_pkg::*;
#(
  parameter int NUM_IN = 128,
  parameter int CHAN_W = 8,
  parameter int ADDR_W = 8,
  localparam int NOUT  = (NUM_IN + 63) / 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NUM_IN-1:0] irq_in,
  output logic [NOUT-1:0]   irq_out,
  output logic [CHAN_W-1:0] chan_sel
);
  localparam int NW = NUM_IN / 32;

  dec_t              dec;
  logic [NUM_IN-1:0] mask_q;
  logic [NUM_IN-1:0] force_q;
  logic [NUM_IN-1:0] status;
  logic [NOUT-1:0]   mdis_q;
  logic [31:0]       rword;

  assign dec = decode_word(32'(bus_addr >> 2), NW);

  irqs_regs #(.NUM_IN(NUM_IN), .NOUT(NOUT), .CHAN_W(CHAN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .dec(dec), .wdata(bus_wdata),
    .mask_q(mask_q), .force_q(force_q), .mdis_q(mdis_q), .ctrl_q(chan_sel)
  );

  irqs_fold #(.NUM_IN(NUM_IN), .NOUT(NOUT)) u_fold (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mask_q(mask_q),
    .force_q(force_q), .mdis_q(mdis_q), .status(status), .irq_out(irq_out)
  );

  irqs_rdmux #(.NUM_IN(NUM_IN), .NOUT(NOUT), .CHAN_W(CHAN_W)) u_rd (
    .dec(dec), .mask_q(mask_q), .force_q(force_q), .status(status),
    .mdis_q(mdis_q), .irq_out(irq_out), .ctrl_q(chan_sel), .rword(rword)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rword;
  end

endmodule

// File: rtl/irqs_chk.sv
`timescale 1ns/1ps
module irqs_chk #(
  parameter int NUM_IN = 128,
  parameter int NOUT   = 2,
  parameter int CHAN_W = 8,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NOUT-1:0]   irq_out,
  input logic [CHAN_W-1:0] chan_sel,
  input logic [NUM_IN-1:0] status_w,
  input logic [NUM_IN-1:0] mask_w,
  input logic [NOUT-1:0]   mdis_w
);
  AST_DIS_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    (mdis_w != '0) |=> ((irq_out & $past(mdis_w)) == '0)); // R6
  AST_IDLE_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (status_w == '0) |=> (irq_out == '0)); // R5
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_w == '0) |-> (status_w == '0)); // R4
  AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && (bus_addr[ADDR_W-1:2] == '0)) |=> $stable(chan_sel)); // R8
endmodule

bind irq_steer_agg irqs_chk #(
  .NUM_IN(NUM_IN), .NOUT(NOUT), .CHAN_W(CHAN_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .irq_out(irq_out), .chan_sel(chan_sel), .status_w(status),
  .mask_w(mask_q), .mdis_w(mdis_q)
);

// File: tb/tb_irq_steer_agg.sv
`timescale 1ns/1ps
module tb_irq_steer_agg;
  localparam int NI = 128;
  localparam int NW = NI / 32;
  localparam int NO = (NI + 63) / 64;
  localparam int CW = 8;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NI-1:0] irq_in = '0;
  logic [NO-1:0] irq_out;
  logic [CW-1:0] chan_sel;

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  irq_steer_agg #(.NUM_IN(NI), .CHAN_W(CW), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .irq_out(irq_out), .chan_sel(chan_sel)
  );

  function automatic int a_mask(int w);  return 4 + 4 * w;          endfunction
  function automatic int a_force(int w); return 4 * NW + 4 + 4 * w; endfunction
  function automatic int a_stat(int w);  return 8 * NW + 4 + 4 * w; endfunction
  function automatic int a_mdis();       return 12 * NW + 4;        endfunction
  function automatic int a_mstat();      return 12 * NW + 8;        endfunction
  function automatic int w_of(int n);    return NW - 1 - n / 32;    endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    tick();
    bus_we = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a);
    tick();
    d = bus_rdata;
  endtask

  task automatic drive(logic [NI-1:0] v);
    @(negedge clk);
    irq_in = v;
  endtask

  task automatic clear_all();
    for (int w = 0; w < NW; w++) begin
      wr(a_mask(w), 32'h0);
      wr(a_force(w), 32'h0);
    end
    wr(a_mdis(), 32'h0);
    drive('0);
    tick();
  endtask

  task automatic t_reset();
    check("R1 irq_out", 32'(irq_out), 32'h0);
    check("R1 chan_sel", 32'(chan_sel), 32'h0);
    rd(0, rv);           check("R1 ctrl", rv, 32'h0);
    rd(a_mask(0), rv);   check("R1 mask", rv, 32'h0);
    rd(a_force(NW-1), rv); check("R1 force", rv, 32'h0);
    rd(a_mdis(), rv);    check("R1 mdis", rv, 32'h0);
  endtask

  task automatic t_regs_rw();
    for (int w = 0; w < NW; w++) wr(a_mask(w), 32'hA5000000 | 32'(w));
    for (int w = 0; w < NW; w++) wr(a_force(w), 32'h00C30000 | 32'(w));
    for (int w = 0; w < NW; w++) begin
      rd(a_mask(w), rv);  check("R2 mask rw", rv, 32'hA5000000 | 32'(w));
      rd(a_force(w), rv); check("R3 force rw R10", rv, 32'h00C30000 | 32'(w));
    end
    clear_all();
  endtask

  task automatic t_status_map();
    for (int w = 0; w < NW; w++) wr(a_mask(w), 32'hFFFFFFFF);
    drive(NI'(1));
    rd(a_stat(w_of(0)), rv); check("R4 input0 in last word", rv, 32'h1);
    check("R5 group0 out", 32'(irq_out), 32'h1);
    rd(a_stat(0), rv); check("R4 word0 idle", rv, 32'h0);
    drive(NI'(1) << 37);
    rd(a_stat(w_of(37)), rv); check("R4 input37", rv, 32'h20);
    drive(NI'(1) << 127);
    rd(a_stat(0), rv); check("R4 input127 word0", rv, 32'h80000000);
    check("R5 group1 out", 32'(irq_out), 32'h2);
    wr(a_mask(0), 32'h7FFFFFFF);
    rd(a_stat(0), rv); check("R4 masked", rv, 32'h0);
    tick();
    check("R2 masked no out", 32'(irq_out), 32'h0);
    clear_all();
  endtask

  task automatic t_groups();
    for (int w = 0; w < NW; w++) wr(a_mask(w), 32'hFFFFFFFF);
    drive(NI'(1) << 63); tick();
    check("R5 input63 group0", 32'(irq_out), 32'h1);
    drive(NI'(1) << 64); tick();
    check("R5 input64 group1", 32'(irq_out), 32'h2);
    clear_all();
  endtask

  task automatic t_force();
    wr(a_force(w_of(70)), 32'h1 << (70 % 32));
    tick();
    check("R3 force unmasked none", 32'(irq_out), 32'h0);
    wr(a_mask(w_of(70)), 32'h1 << (70 % 32));
    rd(a_stat(w_of(70)), rv); check("R3 forced status", rv, 32'h40);
    tick();
    check("R3 forced out", 32'(irq_out), 32'h2);
    clear_all();
  endtask

  task automatic t_mdis_mstat();
    for (int w = 0; w < NW; w++) wr(a_mask(w), 32'hFFFFFFFF);
    drive((NI'(1) << 3) | (NI'(1) << 100)); tick();
    rd(a_mstat(), rv); check("R7 mstat both", rv, 32'h3);
    wr(a_mdis(), 32'hFFFFFFFE);
    rd(a_mdis(), rv); check("R6 mdis width", rv, 32'h2);
    check("R6 group1 silenced", 32'(irq_out), 32'h1);
    tick();
    rd(a_mstat(), rv); check("R7 mstat after dis", rv, 32'h1);
    clear_all();
  endtask

  task automatic t_level();
    wr(a_mask(w_of(5)), 32'h20);
    drive(NI'(1) << 5); tick();
    check("R11 high", 32'(irq_out), 32'h1);
    drive('0); tick();
    check("R11 drops", 32'(irq_out), 32'h0);
    clear_all();
  endtask

  task automatic t_ctrl_unmapped();
    wr(0, 32'hFFFFFF20);
    check("R8 chan_sel", 32'(chan_sel), 32'h20);
    rd(0, rv); check("R8 ctrl read", rv, 32'h20);
    wr(a_mdis() + 8, 32'hFFFFFFFF);
    rd(a_mdis() + 8, rv); check("R9 unmapped read", rv, 32'h0);
    rd(0, rv); check("R9 ctrl untouched", rv, 32'h20);
    wr(a_stat(0), 32'hFFFFFFFF);
    wr(a_mstat(), 32'hFFFFFFFF);
    for (int w = 0; w < NW; w++) begin
      rd(a_mask(w), rv);  check("R9 mask untouched", rv, 32'h0);
      rd(a_force(w), rv); check("R9 force untouched", rv, 32'h0);
    end
    rd(a_mdis(), rv); check("R9 mdis untouched", rv, 32'h0);
    check("R9 chan_sel kept", 32'(chan_sel), 32'h20);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_regs_rw();
    t_status_map();
    t_groups();
    t_force();
    t_mdis_mstat();
    t_level();
    t_ctrl_unmapped();
    finish_run();
  end
endmodule